// File: doc/BRIEF.md
# Prioritised Interrupt Vector Generator

This block sits between the interrupt request lines of a small controller and its instruction fetch unit. Each cycle it looks at every pending request that is allowed to compete, picks the one with the largest priority number, and issues the 16-bit address of the table word that holds that handler's entry point. The table spans 0FFC0h to 0FFFFh. The address is computed as the table base plus twice the priority number, so priority 31 maps to 0FFFEh and priority 0 maps to 0FFC0h.

There are three classes of request. Reset-class sources always win. They share priority 31 and are joined by an internally detected illegal instruction fetch. Non-maskable-class sources share priority 30. Each obeys only its own enable and ignores the global enable. Maskable sources sit at priorities 0 to 29, and bit k of the request vector has priority k. They compete only when both their own enable and the global enable are set. Accepting a maskable source asks the CPU to clear its global enable.

After power-up the block issues the reset vector address and waits for the word read from it. If that word is all ones, the memory is blank, and the block parks the device in its deepest sleep state until a reset-class event occurs.

The controller has five named states:
- ST_POWERUP: issues the reset vector after power-up.
- ST_BOOTCHK: waits for the word read from the reset vector.
- ST_RUN: arbitrates between pending requests.
- ST_HOLD: a one-cycle gap after a non-reset accept.
- ST_DORMANT: deepest sleep after a blank reset vector.

Its transitions are:
- ST_POWERUP goes to ST_BOOTCHK unconditionally.
- ST_BOOTCHK goes to ST_DORMANT when the returned word is blank.
- ST_BOOTCHK goes to ST_RUN when the returned word is anything else.
- ST_BOOTCHK stays in ST_BOOTCHK when a reset-class event arrives.
- ST_RUN goes to ST_BOOTCHK when a reset-class request is accepted.
- ST_RUN goes to ST_HOLD when any other request is accepted.
- ST_HOLD goes to ST_RUN unconditionally.
- ST_DORMANT goes to ST_BOOTCHK when a reset-class event arrives.

Top module: `irq_vector_gen`

## Requirements
- R1: While rst_n is low, vec_valid_o, rst_req_o, gie_clr_o and deep_sleep_o are 0. In the first cycle after release, vec_valid_o is 1 with vec_addr_o = 0FFFEh and rst_req_o = 0.
- R2: In ST_BOOTCHK, a boot word of 0FFFFh with boot_word_vld_i = 1 sets deep_sleep_o from the next cycle. It stays set until a reset-class event is accepted, which clears it in the same cycle that the vector is issued.
- R3: In ST_BOOTCHK, any other boot word moves the block to ST_RUN, where requests are serviced.
- R4: An issued vector address is 0FFC0h + 2 × priority. Reset-class requests give 0FFFEh, non-maskable-class requests give 0FFFCh, and maskable bit 26 (interval timer) gives 0FFF4h.
- R5: In ST_RUN, reset-class beats non-maskable-class, which beats any maskable request. Among maskable requests the highest set bit index wins.
- R6: A maskable bit competes only if its mask_en_i bit and gie_i are both 1.
- R7: A non-maskable-class source competes when its nmi_en_i bit is 1, whatever gie_i is. With its enable 0 it is ignored.
- R8: A request present in ST_RUN at a clock edge gives a vec_valid_o pulse exactly one cycle wide, visible after that edge. The following cycle (ST_HOLD) accepts nothing, even if requests persist.
- R9: gie_clr_o pulses together with vec_valid_o only for maskable accepts.
- R10: In ST_RUN, fetch_valid_i with fetch_addr_i inside a forbidden range counts as a reset-class request. The forbidden ranges are below 0200h, 0280h to 0FFFh, and 1100h to 0F7FFh. Addresses 0200h, 0F800h and 1000h are legal.
- R11: rst_req_o pulses with every accepted reset-class event, but not on the power-up vector.
- R12: In ST_BOOTCHK and ST_DORMANT, non-maskable-class and maskable requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| rst_src_i | input | NUM_RST (4) | Reset-class request lines |
| nmi_req_i | input | NUM_NMI (3) | Non-maskable-class request lines |
| nmi_en_i | input | NUM_NMI (3) | Individual enables for non-maskable-class lines |
| mask_req_i | input | NUM_MASK (30) | Maskable requests; bit k has priority k |
| mask_en_i | input | NUM_MASK (30) | Individual enables for maskable requests |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| fetch_valid_i | input | 1 | Instruction fetch address is valid |
| fetch_addr_i | input | AW (16) | Instruction fetch address |
| boot_word_vld_i | input | 1 | Word read from the reset vector is present |
| boot_word_i | input | AW (16) | Word read from the reset vector |
| vec_valid_o | output | 1 | One-cycle pulse: vector address issued |
| vec_addr_o | output | AW (16) | Vector table address to read |
| rst_req_o | output | 1 | One-cycle pulse: reset raised |
| gie_clr_o | output | 1 | One-cycle pulse: clear the global enable |
| deep_sleep_o | output | 1 | Deepest sleep requested (blank reset vector) |

## Verification
The assertions take for granted that request lines are levels that may hold across cycles. They also assume that gie_i only falls in response to gie_clr_o or by software, so a past sample of gie_i reflects what the arbiter saw. The stimulus draws request, enable and fetch vectors at random each trial and holds them for no more than two edges. After every reset-class accept it supplies a non-blank boot word, which returns the controller to ST_RUN. The assertions therefore see the arbitration state far more often than the power-up path.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_BOOTCHK,
        ST_RUN,
        ST_HOLD,
        ST_DORMANT
    } fsm_t;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_MASK,
        CLS_NMI,
        CLS_RST
    } cls_t;

endpackage

// File: rtl/irq_fetch_guard.sv
module irq_fetch_guard #(
    parameter int AW = 16,
    parameter logic [AW-1:0] LOW_LIMIT = 16'h0200,
    parameter int NUM_GAP = 2,
    parameter logic [NUM_GAP*AW-1:0] GAP_LO = {16'h1100, 16'h0280},
    parameter logic [NUM_GAP*AW-1:0] GAP_HI = {16'hF7FF, 16'h0FFF}
) (
    input  logic [AW-1:0] addr_i,
    output logic          bad_o
);

    logic [NUM_GAP-1:0] gap_hit;

    // one comparator pair per unused address window
    genvar g;
    generate
        for (g = 0; g < NUM_GAP; g++) begin : g_gap
            assign gap_hit[g] = (addr_i >= GAP_LO[g*AW +: AW]) &&
                                (addr_i <= GAP_HI[g*AW +: AW]);
        end
    endgenerate

    assign bad_o = (addr_i < LOW_LIMIT) || (|gap_hit);

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_vec_pkg::*;
#(
    parameter int PRIO_W = 5,
    localparam int LVL_TOP = (1 << PRIO_W) - 1,
    localparam int LVL_NMI = LVL_TOP - 1,
    localparam int NUM_MASK = LVL_TOP - 1
) (
    input  logic                rst_hit_i,
    input  logic                nmi_hit_i,
    input  logic [NUM_MASK-1:0] mask_hit_i,
    output cls_t                win_cls_o,
    output logic [PRIO_W-1:0]   win_prio_o
);

    // later assignments override earlier ones: ascending scan, highest wins
    always_comb begin
        win_cls_o  = CLS_NONE;
        win_prio_o = '0;
        for (int i = 0; i < NUM_MASK; i++) begin
            if (mask_hit_i[i]) begin
                win_cls_o  = CLS_MASK;
                win_prio_o = PRIO_W'(i);
            end
        end
        if (nmi_hit_i) begin
            win_cls_o  = CLS_NMI;
            win_prio_o = PRIO_W'(LVL_NMI);
        end
        if (rst_hit_i) begin
            win_cls_o  = CLS_RST;
            win_prio_o = PRIO_W'(LVL_TOP);
        end
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_vec_pkg::*;
#(
    parameter int AW = 16,
    parameter int PRIO_W = 5,
    parameter int NUM_RST = 4,
    parameter int NUM_NMI = 3,
    parameter logic [AW-1:0] VEC_BASE = 16'hFFC0,
    parameter logic [AW-1:0] LOW_LIMIT = 16'h0200,
    parameter int NUM_GAP = 2,
    parameter logic [NUM_GAP*AW-1:0] GAP_LO = {16'h1100, 16'h0280},
    parameter logic [NUM_GAP*AW-1:0] GAP_HI = {16'hF7FF, 16'h0FFF},
    localparam int LVL_TOP = (1 << PRIO_W) - 1,
    localparam int NUM_MASK = LVL_TOP - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_RST-1:0]  rst_src_i,
    input  logic [NUM_NMI-1:0]  nmi_req_i,
    input  logic [NUM_NMI-1:0]  nmi_en_i,
    input  logic [NUM_MASK-1:0] mask_req_i,
    input  logic [NUM_MASK-1:0] mask_en_i,
    input  logic                gie_i,
    input  logic                fetch_valid_i,
    input  logic [AW-1:0]       fetch_addr_i,
    input  logic                boot_word_vld_i,
    input  logic [AW-1:0]       boot_word_i,
    output logic                vec_valid_o,
    output logic [AW-1:0]       vec_addr_o,
    output logic                rst_req_o,
    output logic                gie_clr_o,
    output logic                deep_sleep_o
);

    localparam int PAD_W = AW - PRIO_W - 1;
    localparam logic [AW-1:0] RST_ADDR = VEC_BASE + AW'(2 * LVL_TOP);

    fsm_t state_q, state_d;

    logic                fetch_bad;
    logic                fetch_fault;
    logic                rst_hit;
    logic                nmi_hit;
    logic [NUM_MASK-1:0] mask_hit;
    cls_t                win_cls;
    logic [PRIO_W-1:0]   win_prio;
    logic [AW-1:0]       win_addr;

    logic                emit_d;
    logic [AW-1:0]       emit_addr_d;
    logic                emit_rst_d;
    logic                emit_mask_d;

    irq_fetch_guard #(
        .AW       (AW),
        .LOW_LIMIT(LOW_LIMIT),
        .NUM_GAP  (NUM_GAP),
        .GAP_LO   (GAP_LO),
        .GAP_HI   (GAP_HI)
    ) u_guard (
        .addr_i(fetch_addr_i),
        .bad_o (fetch_bad)
    );

    // request qualification
    assign fetch_fault = fetch_valid_i && fetch_bad && (state_q == ST_RUN);
    assign rst_hit     = (|rst_src_i) || fetch_fault;
    assign nmi_hit     = |(nmi_req_i & nmi_en_i);
    assign mask_hit    = mask_req_i & mask_en_i & {NUM_MASK{gie_i}};

    irq_prio_sel #(
        .PRIO_W(PRIO_W)
    ) u_sel (
        .rst_hit_i (rst_hit),
        .nmi_hit_i (nmi_hit),
        .mask_hit_i(mask_hit),
        .win_cls_o (win_cls),
        .win_prio_o(win_prio)
    );

    assign win_addr = VEC_BASE + {{PAD_W{1'b0}}, win_prio, 1'b0};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and accept decision
    always_comb begin
        state_d     = state_q;
        emit_d      = 1'b0;
        emit_addr_d = RST_ADDR;
        emit_rst_d  = 1'b0;
        emit_mask_d = 1'b0;
        unique case (state_q)
            ST_POWERUP: begin
                emit_d  = 1'b1;
                state_d = ST_BOOTCHK;
            end
            ST_BOOTCHK: begin
                if (rst_hit) begin
                    emit_d     = 1'b1;
                    emit_rst_d = 1'b1;
                end else if (boot_word_vld_i) begin
                    state_d = (boot_word_i == '1) ? ST_DORMANT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (win_cls != CLS_NONE) begin
                    emit_d      = 1'b1;
                    emit_addr_d = win_addr;
                    emit_rst_d  = (win_cls == CLS_RST);
                    emit_mask_d = (win_cls == CLS_MASK);
                    state_d     = (win_cls == CLS_RST) ? ST_BOOTCHK : ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_RUN;
            end
            ST_DORMANT: begin
                if (rst_hit) begin
                    emit_d     = 1'b1;
                    emit_rst_d = 1'b1;
                    state_d    = ST_BOOTCHK;
                end
            end
            default: begin
                state_d = ST_POWERUP;
            end
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid_o  <= 1'b0;
            vec_addr_o   <= '0;
            rst_req_o    <= 1'b0;
            gie_clr_o    <= 1'b0;
            deep_sleep_o <= 1'b0;
        end else begin
            vec_valid_o  <= emit_d;
            rst_req_o    <= emit_rst_d;
            gie_clr_o    <= emit_mask_d;
            deep_sleep_o <= (state_d == ST_DORMANT);
            if (emit_d) begin
                vec_addr_o <= emit_addr_d;
            end
        end
    end

endmodule

// File: rtl/irq_vector_gen_chk.sv
module irq_vector_gen_chk #(
    parameter int AW = 16,
    parameter int PRIO_W = 5,
    parameter int NUM_NMI = 3,
    parameter logic [AW-1:0] VEC_BASE = 16'hFFC0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_valid_o,
    input logic [AW-1:0]      vec_addr_o,
    input logic               rst_req_o,
    input logic               gie_clr_o,
    input logic               deep_sleep_o,
    input logic               gie_i,
    input logic [NUM_NMI-1:0] nmi_req_i,
    input logic [NUM_NMI-1:0] nmi_en_i
);

    localparam int LVL_TOP = (1 << PRIO_W) - 1;
    localparam logic [AW-1:0] TOP_ADDR = VEC_BASE + AW'(2 * LVL_TOP);
    localparam logic [AW-1:0] NMI_ADDR = VEC_BASE + AW'(2 * (LVL_TOP - 1));

    p_addr_in_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_addr_o[0] == 1'b0 && vec_addr_o >= VEC_BASE));

    p_gie_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_o |-> $past(gie_i));

    p_nmi_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !rst_req_o && vec_addr_o == NMI_ADDR) |->
            $past(|(nmi_req_i & nmi_en_i)));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    p_gie_clr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_o |-> (vec_valid_o && !rst_req_o && vec_addr_o < NMI_ADDR));

    p_rst_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (vec_valid_o && vec_addr_o == TOP_ADDR));

    p_dormant_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep_o |=> (!vec_valid_o || rst_req_o));

endmodule

bind irq_vector_gen irq_vector_gen_chk #(
    .AW      (AW),
    .PRIO_W  (PRIO_W),
    .NUM_NMI (NUM_NMI),
    .VEC_BASE(VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .rst_req_o   (rst_req_o),
    .gie_clr_o   (gie_clr_o),
    .deep_sleep_o(deep_sleep_o),
    .gie_i       (gie_i),
    .nmi_req_i   (nmi_req_i),
    .nmi_en_i    (nmi_en_i)
);

// File: tb/sim_irq_vector_gen.sv
`timescale 1ns/1ps
module sim_irq_vector_gen;

    localparam int NR = 4;
    localparam int NN = 3;
    localparam int NM = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rst_src = '0;
    logic [NN-1:0] nmi_req = '0;
    logic [NN-1:0] nmi_en = '0;
    logic [NM-1:0] mask_req = '0;
    logic [NM-1:0] mask_en = '0;
    logic          gie = 1'b0;
    logic          fv = 1'b0;
    logic [15:0]   fa = '0;
    logic          bvld = 1'b0;
    logic [15:0]   bword = '0;
    logic          vvalid;
    logic [15:0]   vaddr;
    logic          rreq;
    logic          gclr;
    logic          dsleep;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    irq_vector_gen u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .rst_src_i      (rst_src),
        .nmi_req_i      (nmi_req),
        .nmi_en_i       (nmi_en),
        .mask_req_i     (mask_req),
        .mask_en_i      (mask_en),
        .gie_i          (gie),
        .fetch_valid_i  (fv),
        .fetch_addr_i   (fa),
        .boot_word_vld_i(bvld),
        .boot_word_i    (bword),
        .vec_valid_o    (vvalid),
        .vec_addr_o     (vaddr),
        .rst_req_o      (rreq),
        .gie_clr_o      (gclr),
        .deep_sleep_o   (dsleep)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        rst_src = '0; nmi_req = '0; nmi_en = '0; mask_req = '0; mask_en = '0;
        gie = 1'b0; fv = 1'b0; fa = '0; bvld = 1'b0;
    endtask

    // fetch address rule, R10
    function automatic logic fetch_forbidden(input logic [15:0] a);
        return (a < 16'h0200) || (a >= 16'h0280 && a <= 16'h0FFF) ||
               (a >= 16'h1100 && a <= 16'hF7FF);
    endfunction

    // expected {valid, rst_req, gie_clr, addr} from ST_RUN, R4 R5 R6 R7
    function automatic logic [18:0] expect_run();
        logic [NM-1:0] mh;
        mh = mask_req & mask_en & {NM{gie}};
        if ((|rst_src) || (fv && fetch_forbidden(fa)))
            return {3'b110, 16'hFFFE};
        if (|(nmi_req & nmi_en))
            return {3'b100, 16'hFFFC};
        for (int k = NM - 1; k >= 0; k--)
            if (mh[k]) return {3'b101, 16'hFFC0 + 16'(2 * k)};
        return {3'b000, 16'h0000};
    endfunction

    task automatic check_accept(input string tag, input logic [18:0] e);
        check({tag, " valid"}, {31'd0, vvalid}, {31'd0, e[18]});
        check({tag, " R11 rst_req"}, {31'd0, rreq}, {31'd0, e[17]});
        check({tag, " R9 gie_clr"}, {31'd0, gclr}, {31'd0, e[16]});
        if (e[18]) check({tag, " R4 addr"}, {16'd0, vaddr}, {16'd0, e[15:0]});
    endtask

    // return to ST_RUN after a reset-class accept, R3
    task automatic reboot(input logic [15:0] w);
        clear_in();
        bvld = 1'b1; bword = w;
        step();
        bvld = 1'b0;
        check("R3 no vector on boot word", {31'd0, vvalid}, 32'd0);
    endtask

    task automatic trial(input string tag);
        logic [18:0] e;
        e = expect_run();
        step();
        check_accept(tag, e);
        if (e[18] && e[17]) begin
            reboot(16'h4400);
        end else if (e[18]) begin
            step();
            check({tag, " R8 hold gap"}, {31'd0, vvalid}, 32'd0);
            clear_in();
        end else begin
            clear_in();
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        clear_in();
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, vvalid}, 32'd0);
        check("R1 flags in reset", {29'd0, rreq, gclr, dsleep}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R1 power-up vector", {15'd0, vvalid, vaddr}, {15'd0, 1'b1, 16'hFFFE});
        check("R11 no rst_req on power-up", {31'd0, rreq}, 32'd0);
        step();
        check("R8 power-up pulse width", {31'd0, vvalid}, 32'd0);

        // blank reset vector -> dormant, R2
        bvld = 1'b1; bword = 16'hFFFF;
        step();
        bvld = 1'b0;
        check("R2 deep sleep set", {31'd0, dsleep}, 32'd1);
        nmi_req = 3'b111; nmi_en = 3'b111; mask_req = '1; mask_en = '1; gie = 1'b1;
        step();
        check("R12 dormant ignores irq", {31'd0, vvalid}, 32'd0);
        check("R2 deep sleep held", {31'd0, dsleep}, 32'd1);
        clear_in();
        rst_src = 4'b0100;
        step();
        check_accept("R2 wake by reset", {3'b110, 16'hFFFE});
        check("R2 deep sleep cleared", {31'd0, dsleep}, 32'd0);
        clear_in();
        nmi_req = 3'b001; nmi_en = 3'b001;
        step();
        check("R12 boot-check ignores nmi", {31'd0, vvalid}, 32'd0);
        reboot(16'hF800);

        // directed corner cases
        mask_req[26] = 1'b1; mask_en[26] = 1'b1; gie = 1'b1;
        trial("R4 interval timer 0FFF4h");
        mask_req = '1; mask_en = '1; gie = 1'b0;
        trial("R6 gie low blocks maskable");
        mask_req = 30'h0000_0FFF; mask_en = 30'h0000_0F0F; gie = 1'b1;
        trial("R5 R6 highest enabled bit");
        nmi_req = 3'b010; nmi_en = 3'b010; gie = 1'b0; mask_req = '1; mask_en = '1;
        trial("R7 nmi ignores gie");
        nmi_req = 3'b010; nmi_en = 3'b101;
        trial("R7 nmi own enable off");
        fv = 1'b1; fa = 16'h01FF;
        trial("R10 fetch 01FFh");
        fv = 1'b1; fa = 16'h0200;
        trial("R10 fetch 0200h legal");
        fv = 1'b1; fa = 16'hF7FF;
        trial("R10 fetch F7FFh");
        fv = 1'b1; fa = 16'hF800;
        trial("R10 fetch F800h legal");
        fv = 1'b1; fa = 16'h1000;
        trial("R10 fetch 1000h legal");
        rst_src = 4'b0001; nmi_req = 3'b111; nmi_en = 3'b111;
        trial("R5 reset beats nmi");

        // constrained random
        for (int t = 0; t < 600; t++) begin
            logic [15:0] picks [6];
            picks[0] = 16'h0100; picks[1] = 16'h0240; picks[2] = 16'h0800;
            picks[3] = 16'h1080; picks[4] = 16'h9000; picks[5] = 16'hFC00;
            rst_src  = (($urandom % 8) == 0) ? NR'($urandom) : '0;
            nmi_req  = (($urandom % 4) == 0) ? NN'($urandom) : '0;
            nmi_en   = NN'($urandom);
            mask_req = NM'($urandom) & NM'($urandom);
            mask_en  = NM'($urandom);
            gie      = 1'($urandom);
            fv       = (($urandom % 4) == 0);
            fa       = picks[$urandom % 6] + 16'($urandom % 64);
            trial("R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule